// File: doc/BRIEF.md
# Sampled-Clock Register Emulator

This block reproduces the behaviour of an edge-triggered register, with an optional asynchronous reset, using only logic clocked by a single fast global clock. The emulated register's clock, its data bus and its reset are treated as plain signals. They are looked at on every global tick, and none of them ever drives a clock pin. This makes it possible to place a register with its own clock domain inside a single-clock environment, such as a formal model or a fast emulation fabric.

Three registers do the work. The first keeps the previous tick's level of the emulated clock. The second keeps the previous tick's data. The third keeps the previous tick's output. An active edge is recognised when the current level and the stored level of the emulated clock form the active pair. On an active edge, the output presents the stored data. Otherwise it presents the stored output. When the reset variant is built and its reset input is active, a fixed reset value replaces the output. This happens combinationally in the same tick.

The stored clock level powers up at the active level. Because of this, the first tick can never look like an edge. The stored output powers up at the declared initial value.

Top module: `ffemu_top`

## Requirements
- R1: Before any active edge and with no reset applied, `q_o` equals the parameter `INIT_VAL` (default all zeros).
- R2: With `CLK_POL = EDGE_RISE`, an active edge is a tick in which `mclk_i` is 1 and was 0 in the previous tick. In that tick `q_o` equals the value of `data_i` at the previous global clock edge. A change of `data_i` within the edge tick itself has no effect.
- R3: With `CLK_POL = EDGE_FALL`, an active edge is a tick in which `mclk_i` is 0 and was 1 in the previous tick. The output follows the same capture rule as R2.
- R4: In a tick with no active edge and no active reset, `q_o` keeps the value it had in the previous tick. This holds when the emulated clock changes in the inactive direction, and it holds whatever `data_i` does.
- R5: The first global tick never counts as an active edge, whatever level `mclk_i` starts at.
- R6: With `HAS_RST = 1` and `RST_POL = RST_HIGH`, a high `rst_i` forces `q_o` to `RST_VAL` in the same tick. The reset takes priority even in a tick that has an active edge.
- R7: After the reset is released, `q_o` holds `RST_VAL` until the next active edge.
- R8: With `HAS_RST = 0`, `rst_i` has no effect on `q_o`.
- R9: With `RST_POL = RST_LOW`, the reset is active when `rst_i` is 0. It then behaves as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk_i | input | 1 | Global sampling clock; every register in the block is clocked by its rising edge |
| mclk_i | input | 1 | Emulated register clock, treated as data |
| data_i | input | DATA_W | Emulated register data input |
| rst_i | input | 1 | Emulated asynchronous reset; its polarity is set by `RST_POL`; it is unused when `HAS_RST = 0` |
| q_o | output | DATA_W | Emulated register output, driven combinationally |

## Verification
Each output value is due in the same global period in which the emulated clock or the reset changes. The output is a mux of registers written at the previous global edge and of the current `mclk_i` and `rst_i`. The state behind a held value therefore becomes visible one tick after the value first appears. The bench changes all inputs one nanosecond after a rising global edge and compares `q_o` on the following falling edge. Its reference models capture the data that was present at the preceding rising edge, which models the one-tick data delay. Three instances cover rising and falling capture, high-active and low-active reset, and the build with no reset.

// File: rtl/ffemu_pkg.sv
package ffemu_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;

    typedef enum logic {
        RST_LOW  = 1'b0,
        RST_HIGH = 1'b1
    } rst_pol_e;

    // Level the emulated clock rests at just after an active edge.
    function automatic logic active_level(edge_pol_e pol);
        return (pol == EDGE_RISE);
    endfunction

    // True when the pair (current level, stored level) is the active pair.
    function automatic logic edge_hit(edge_pol_e pol, logic now_lvl, logic prev_lvl);
        logic [1:0] pair;
        pair = {now_lvl, prev_lvl};
        if (pol == EDGE_RISE) begin
            return (pair == 2'b10);
        end
        return (pair == 2'b01);
    endfunction

    // True when the reset input is at its asserting level.
    function automatic logic rst_asserted(rst_pol_e pol, logic lvl);
        return (lvl == (pol == RST_HIGH));
    endfunction

endpackage

// File: rtl/ffemu_clk_track.sv
module ffemu_clk_track
    import ffemu_pkg::*;
#(
    parameter edge_pol_e CLK_POL = EDGE_RISE
) (
    input  logic gclk_i,
    input  logic mclk_i,
    output logic edge_o
);

    typedef struct packed {
        logic lvl;
    } trk_t;

    // Starts at the active level so that the first tick cannot form an edge.
    trk_t trk_q = '{lvl: active_level(CLK_POL)};
    trk_t trk_d;

    always_comb begin
        trk_d     = trk_q;
        trk_d.lvl = mclk_i;
    end

    always_ff @(posedge gclk_i) begin
        trk_q <= trk_d;
    end

    assign edge_o = edge_hit(CLK_POL, mclk_i, trk_q.lvl);

endmodule

// File: rtl/ffemu_hist.sv
module ffemu_hist #(
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
    input  logic              gclk_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] q_i,
    output logic [DATA_W-1:0] past_data_o,
    output logic [DATA_W-1:0] past_q_o
);

    typedef struct packed {
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] out;
    } hist_t;

    hist_t hist_q = '{dat: '0, out: INIT_VAL};
    hist_t hist_d;

    always_comb begin
        hist_d     = hist_q;
        hist_d.dat = data_i;
        hist_d.out = q_i;
    end

    always_ff @(posedge gclk_i) begin
        hist_q <= hist_d;
    end

    assign past_data_o = hist_q.dat;
    assign past_q_o    = hist_q.out;

endmodule

// File: rtl/ffemu_select.sv
module ffemu_select
    import ffemu_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter bit                HAS_RST = 1'b1,
    parameter rst_pol_e          RST_POL = RST_HIGH,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              edge_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] past_data_i,
    input  logic [DATA_W-1:0] past_q_i,
    output logic [DATA_W-1:0] q_o
);

    logic [DATA_W-1:0] clk_sel;

    // Capture on an edge, otherwise hold.
    assign clk_sel = edge_i ? past_data_i : past_q_i;

    generate
        if (HAS_RST) begin : g_rst
            logic rst_on;
            assign rst_on = rst_asserted(RST_POL, rst_i);
            assign q_o    = rst_on ? RST_VAL : clk_sel;
        end else begin : g_norst
            logic unused_rst;
            assign unused_rst = rst_i;
            assign q_o        = clk_sel;
        end
    endgenerate

endmodule

// File: rtl/ffemu_top.sv
module ffemu_top
    import ffemu_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter edge_pol_e         CLK_POL  = EDGE_RISE,
    parameter bit                HAS_RST  = 1'b1,
    parameter rst_pol_e          RST_POL  = RST_HIGH,
    parameter logic [DATA_W-1:0] RST_VAL  = '0,
    parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
    input  logic              gclk_i,
    input  logic              mclk_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rst_i,
    output logic [DATA_W-1:0] q_o
);

    logic              edge_w;
    logic [DATA_W-1:0] past_data_w;
    logic [DATA_W-1:0] past_q_w;

    ffemu_clk_track #(
        .CLK_POL (CLK_POL)
    ) u_clk_track (
        .gclk_i (gclk_i),
        .mclk_i (mclk_i),
        .edge_o (edge_w)
    );

    ffemu_hist #(
        .DATA_W   (DATA_W),
        .INIT_VAL (INIT_VAL)
    ) u_hist (
        .gclk_i      (gclk_i),
        .data_i      (data_i),
        .q_i         (q_o),
        .past_data_o (past_data_w),
        .past_q_o    (past_q_w)
    );

    ffemu_select #(
        .DATA_W  (DATA_W),
        .HAS_RST (HAS_RST),
        .RST_POL (RST_POL),
        .RST_VAL (RST_VAL)
    ) u_select (
        .edge_i      (edge_w),
        .rst_i       (rst_i),
        .past_data_i (past_data_w),
        .past_q_i    (past_q_w),
        .q_o         (q_o)
    );

endmodule

// File: rtl/ffemu_chk.sv
module ffemu_chk
    import ffemu_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter edge_pol_e         CLK_POL  = EDGE_RISE,
    parameter bit                HAS_RST  = 1'b1,
    parameter rst_pol_e          RST_POL  = RST_HIGH,
    parameter logic [DATA_W-1:0] RST_VAL  = '0,
    parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
    input logic              gclk_i,
    input logic              mclk_i,
    input logic [DATA_W-1:0] data_i,
    input logic              rst_i,
    input logic [DATA_W-1:0] q_o
);

    localparam bit RISE = (CLK_POL == EDGE_RISE);

    logic seen_q = 1'b0;
    logic rst_on;

    always_ff @(posedge gclk_i) begin
        seen_q <= 1'b1;
    end

    always_comb begin
        rst_on = HAS_RST && (rst_i == (RST_POL == RST_HIGH));
    end

    // R1 and R5: the first tick shows the initial value.
    p_init_r1: assert property (@(posedge gclk_i) disable iff (rst_on)
        !seen_q |-> (q_o == INIT_VAL));

    p_capture_r2: assert property (@(posedge gclk_i) disable iff (rst_on || !seen_q)
        (RISE && $rose(mclk_i)) |-> (q_o == $past(data_i)));

    p_capture_r3: assert property (@(posedge gclk_i) disable iff (rst_on || !seen_q)
        (!RISE && $fell(mclk_i)) |-> (q_o == $past(data_i)));

    // R4 and R7: with no active edge the output does not move.
    p_hold_r4: assert property (@(posedge gclk_i) disable iff (rst_on || !seen_q)
        !(RISE ? $rose(mclk_i) : $fell(mclk_i)) |-> $stable(q_o));

    // R6 and R9: an asserted reset shows the reset value.
    p_reset_r6: assert property (@(posedge gclk_i) disable iff (!seen_q)
        rst_on |-> (q_o == RST_VAL));

endmodule

bind ffemu_top ffemu_chk #(
    .DATA_W   (DATA_W),
    .CLK_POL  (CLK_POL),
    .HAS_RST  (HAS_RST),
    .RST_POL  (RST_POL),
    .RST_VAL  (RST_VAL),
    .INIT_VAL (INIT_VAL)
) u_ffemu_chk (
    .gclk_i (gclk_i),
    .mclk_i (mclk_i),
    .data_i (data_i),
    .rst_i  (rst_i),
    .q_o    (q_o)
);

// File: tb/test_ffemu_top.sv
`timescale 1ns/1ps
module test_ffemu_top;
    import ffemu_pkg::*;

    logic       gclk = 1'b0;
    logic       mclk = 1'b1;
    logic [7:0] dat  = 8'h00;
    logic       rst_h = 1'b0;
    logic       rst_l = 1'b1;
    logic [7:0] q_a, q_b, q_c;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;
    bit done = 1'b0;

    // bench reference state
    logic       prev_m = 1'b1;
    logic [7:0] d_prev = 8'h00;
    logic [7:0] exp_a = 8'h3C;
    logic [7:0] exp_b = 8'h00;
    logic [7:0] exp_c = 8'h00;
    bit         rst_a_prev = 1'b0;
    bit         rst_c_prev = 1'b0;
    bit         first = 1'b1;

    always #5 gclk = ~gclk;

    // rising edge, high reset
    ffemu_top #(.DATA_W(8), .CLK_POL(EDGE_RISE), .HAS_RST(1'b1), .RST_POL(RST_HIGH),
                .RST_VAL(8'hA5), .INIT_VAL(8'h3C)) i_ffemu_top (
        .gclk_i(gclk), .mclk_i(mclk), .data_i(dat), .rst_i(rst_h), .q_o(q_a));

    // falling edge, no reset, default initial value
    ffemu_top #(.DATA_W(8), .CLK_POL(EDGE_FALL), .HAS_RST(1'b0), .RST_POL(RST_HIGH),
                .RST_VAL(8'hFF)) i_ffemu_top_fall (
        .gclk_i(gclk), .mclk_i(mclk), .data_i(dat), .rst_i(rst_h), .q_o(q_b));

    // rising edge, low reset
    ffemu_top #(.DATA_W(8), .CLK_POL(EDGE_RISE), .HAS_RST(1'b1), .RST_POL(RST_LOW),
                .RST_VAL(8'h0F)) i_ffemu_top_lowrst (
        .gclk_i(gclk), .mclk_i(mclk), .data_i(dat), .rst_i(rst_l), .q_o(q_c));

    function automatic logic [7:0] next_val(logic rst_act, logic hit, logic [7:0] cur,
                                            logic [7:0] dp, logic [7:0] rv);
        if (rst_act) return rv;
        if (hit) return dp;
        return cur;
    endfunction

    task automatic check(input string req, input string inst, input logic [7:0] act,
                         input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h expected %h", req, inst, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic [7:0] dv, input logic rh, input logic rl);
        logic er, ef;
        string ta, tb, tc;
        @(posedge gclk);
        #1;
        mclk = m; dat = dv; rst_h = rh; rst_l = rl;
        @(negedge gclk);
        er = m && !prev_m;
        ef = !m && prev_m;
        exp_a = next_val(rh, er, exp_a, d_prev, 8'hA5);
        exp_b = next_val(1'b0, ef, exp_b, d_prev, 8'hFF);
        exp_c = next_val(!rl, er, exp_c, d_prev, 8'h0F);
        if (first) begin
            ta = "R1/R5"; tb = "R1/R5"; tc = "R1/R5";
        end else begin
            ta = rh ? "R6" : er ? "R2" : rst_a_prev ? "R7" : "R4";
            tb = rh ? "R8" : ef ? "R3" : "R4";
            tc = !rl ? "R9" : er ? "R2" : rst_c_prev ? "R7" : "R4";
        end
        check(ta, "rise_hrst", q_a, exp_a);
        check(tb, "fall_norst", q_b, exp_b);
        check(tc, "rise_lrst", q_c, exp_c);
        first = 1'b0;
        rst_a_prev = rh;
        rst_c_prev = !rl;
        prev_m = m;
        d_prev = dv;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    always @(posedge gclk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20251));
        // R1, R5: clock starts at the rising active level, no capture
        step(1'b1, 8'h11, 1'b0, 1'b1);
        step(1'b1, 8'h12, 1'b0, 1'b1);
        // R3 on falling instance; R4 inactive edge for rising ones
        step(1'b0, 8'h22, 1'b0, 1'b1);
        step(1'b0, 8'h33, 1'b0, 1'b1);
        // R2: capture 33, the new 44 in the same tick is ignored
        step(1'b1, 8'h44, 1'b0, 1'b1);
        step(1'b1, 8'h45, 1'b0, 1'b1);
        // R6, R9, R8: reset asserted, also across an active edge
        step(1'b1, 8'h55, 1'b1, 1'b0);
        step(1'b0, 8'h56, 1'b1, 1'b0);
        step(1'b1, 8'h66, 1'b1, 1'b0);
        // R7: release holds reset value
        step(1'b1, 8'h77, 1'b0, 1'b1);
        step(1'b1, 8'h78, 1'b0, 1'b1);
        step(1'b0, 8'h79, 1'b0, 1'b1);
        step(1'b1, 8'h7A, 1'b0, 1'b1);
        // constrained random mix
        for (int i = 0; i < 800; i++) begin
            step(1'($urandom % 2), 8'($urandom), ($urandom % 12) == 0, ($urandom % 12) != 0);
        end
        finish_run();
    end

endmodule